// File: doc/BRIEF.md
# Frequency-Select Strap Latch and Control Merge

This block owns the select and control path of a clock generator whose frequency-select inputs share pads with clock outputs. When reset releases, the five shared pads (four frequency straps and one CPU-voltage strap) still act as inputs. For a fixed window of reference-clock cycles the block samples them. At the end of the window it latches them and hands the pads over to their output drivers by raising the pad output enables.

After the latch, the block builds a 5-bit select code. It takes that code either from the latched straps or from a control byte written over the serial control interface. It also flags which spread style the chosen code implies. Alongside the code it drives a spread enable, a global tristate, a 24/48 MHz select for the auxiliary output and the voltage-dependent skew select. Each time the select code takes a new value, the block raises a one-cycle strobe so that downstream synthesis can retune cleanly. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While reset is asserted, `pad_oe_o`=0, `strap_done_o`=0, `fsel_o`=0, `fsel_chg_o`=0, `vlow_o`=0, `sprd_en_o`=1, `tri_o`=0 and `clk48_sel_o`=0. The control byte resets to 8'h22 and the auxiliary bit resets to 0.
- R2: The pads are sampled on each of the first SAMPLE_CYC rising edges after reset releases. A strap latches as 1 only if it was high on every one of those samples. An undriven pad reads low, so it latches as 0. `strap_done_o` rises after edge SAMPLE_CYC.
- R3: All bits of `pad_oe_o` stay 0 until the straps are latched. After the latch they are all 1, except while the tristate bit (control byte bit 0) is 1, when they are all 0.
- R4: Latched straps, including `vlow_o`, hold until the next reset. Pad activity after the latch has no effect on `fsel_o` or `vlow_o`.
- R5: Control byte bit 3 chooses the source of the select code: 0 takes it from the straps, 1 takes it from the register. On the register path, `fsel_o`[4:0] = {bit7, bit2, bit6, bit5, bit4} of the control byte. On the strap path, `fsel_o`[3:0] = `pad_fs_i`[3:0] as latched.
- R6: Only the register path can set `fsel_o`[4]. Whenever the straps are the source, `fsel_o`[4] is 0.
- R7: `sprd_center_o`=1 (center spread) when `fsel_o`[4]=1. When `fsel_o`[4]=0, `sprd_center_o`=0 (down spread) for `fsel_o`[3:0] in {0,1,3,5,7,9,15}, and `sprd_center_o`=1 for every other value.
- R8: `fsel_chg_o` is high in exactly the cycles in which `fsel_o` has just taken a new value. A write that leaves the code unchanged gives no strobe. Before the latch, `fsel_o` stays 0 and there is no strobe.
- R9: `fsel_o` updates one rising edge after its source changes. This means edge SAMPLE_CYC+1 after reset for the strap latch, and the edge after the write edge for a register write.
- R10: A write with `cfg_addr_i`=0 loads the control byte; `sprd_en_o` (bit 1) and `tri_o` (bit 0) follow it right after the write edge. A write with `cfg_addr_i`=1 loads `clk48_sel_o` from data bit 7 (1 = 48 MHz). `vlow_o`=1 means the voltage strap latched high (2.5 V skew).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_fs_i | input | 4 | Frequency straps as read from the shared pads |
| pad_vsel_i | input | 1 | CPU-voltage strap as read from its shared pad |
| pad_oe_o | output | 5 | Output enables of the shared pads ({vsel, fs3..fs0}) |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_addr_i | input | 1 | 0 selects the control byte, 1 the auxiliary byte |
| cfg_wdata_i | input | 8 | Write data |
| strap_done_o | output | 1 | Straps latched |
| fsel_o | output | 5 | Effective frequency select code |
| fsel_chg_o | output | 1 | One-cycle strobe on a new select code |
| sprd_en_o | output | 1 | Spread spectrum enable |
| sprd_center_o | output | 1 | 1 = center spread, 0 = down spread |
| clk48_sel_o | output | 1 | Auxiliary output 1 = 48 MHz, 0 = 24 MHz |
| vlow_o | output | 1 | 1 = 2.5 V CPU skew settings, 0 = 3.3 V |
| tri_o | output | 1 | Tristate all outputs |

## Verification
The assertions assume that reset starts asserted, so the first past-value comparison sees reset values. They also assume a write strobe lasts one cycle and carries a defined address and defined data. The bench applies reset at the start of every trial and drives the pads and the write port only between clock edges. It pulses `cfg_we_i` for one cycle and then leaves at least two idle cycles, so that each write's strobe and code update can be observed apart. The random strap patterns include pads held low, pads held high and pads that dip low on a single sample inside the window.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int STRAP_W = 4;
  localparam int PAD_W   = STRAP_W + 1;
  localparam int FS_W    = 5;
  localparam int REG_W   = 8;

  // control byte bit positions
  localparam int B_FS4  = 7;
  localparam int B_FS2  = 6;
  localparam int B_FS1  = 5;
  localparam int B_FS0  = 4;
  localparam int B_SRC  = 3;
  localparam int B_FS3  = 2;
  localparam int B_SPRD = 1;
  localparam int B_TRI  = 0;
  localparam int B_48   = 7;

  localparam logic [REG_W-1:0] CTL_RST = 8'h22;
  localparam logic             AUX_RST = 1'b0;

  // select codes (FS4=0) whose spread is down-only; all others are center
  localparam logic [15:0] DOWN_MAP = 16'h82AB;

  typedef struct packed {
    logic            src_reg;
    logic [FS_W-1:0] fs;
    logic            sprd;
    logic            tri_all;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [REG_W-1:0] b);
    ctl_t c;
    c.src_reg = b[B_SRC];
    c.fs      = {b[B_FS4], b[B_FS3], b[B_FS2], b[B_FS1], b[B_FS0]};
    c.sprd    = b[B_SPRD];
    c.tri_all = b[B_TRI];
    return c;
  endfunction
endpackage

// File: rtl/fsel_strap_sampler.sv
module fsel_strap_sampler #(
  parameter int N_CYC = 8,
  parameter int W     = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] strap_o,
  output logic         done_o
);
  localparam int CNT_W = (N_CYC > 1) ? $clog2(N_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_w;

  assign last_w = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (last_w) done_q <= 1'b1;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  // one all-high filter per pad: a single low sample clears the strap
  for (genvar g = 0; g < W; g++) begin : g_pad
    logic acc_q;
    logic lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= 1'b1;
        lat_q <= 1'b0;
      end else if (!done_q) begin
        acc_q <= acc_q & pad_i[g];
        if (last_w) lat_q <= acc_q & pad_i[g];
      end
    end
    assign strap_o[g] = lat_q;
  end

  assign done_o = done_q;

  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_q) |-> $stable(strap_o)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_q) |-> done_q); // R4
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_PRE_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> strap_o == '0); // R2
endmodule

// File: rtl/fsel_cfg_regs.sv
module fsel_cfg_regs
  import fsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctl_o,
  output logic             sel48_o
);
  logic [REG_W-1:0] ctl_q;
  logic             sel48_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= CTL_RST;
      sel48_q <= AUX_RST;
    end else if (we_i) begin
      if (!addr_i) ctl_q   <= wdata_i;
      else         sel48_q <= wdata_i[B_48];
    end
  end

  assign ctl_o   = ctl_q;
  assign sel48_o = sel48_q;

  AST_CTL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(we_i && !addr_i)) |-> $stable(ctl_o)); // R10
  AST_AUX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(we_i && addr_i)) |-> $stable(sel48_o)); // R10
endmodule

// File: rtl/fsel_select_mux.sv
module fsel_select_mux
  import fsel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic               src_reg_i,
  input  logic [FS_W-1:0]    reg_fs_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [FS_W-1:0]    fsel_o,
  output logic               chg_o,
  output logic               center_o
);
  logic [FS_W-1:0] nxt_w;
  logic [FS_W-1:0] fsel_q;
  logic            chg_q;

  always_comb begin
    if (src_reg_i) nxt_w = reg_fs_i;
    else           nxt_w = {1'b0, strap_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= '0;
      chg_q  <= 1'b0;
    end else if (done_i) begin
      fsel_q <= nxt_w;
      chg_q  <= (nxt_w != fsel_q);
    end
  end

  assign fsel_o   = fsel_q;
  assign chg_o    = chg_q;
  assign center_o = fsel_q[FS_W-1] | ~DOWN_MAP[fsel_q[STRAP_W-1:0]];

  AST_CHG_ON_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsel_o != $past(fsel_o)) |-> chg_o); // R8
  AST_CHG_ONLY_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (fsel_o != $past(fsel_o))); // R8
  AST_PRELATCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> (fsel_o == '0 && !chg_o)); // R8
  AST_FS4_STRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!src_reg_i) |-> !fsel_o[FS_W-1]); // R6
  AST_FS4_CENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsel_o[FS_W-1] |-> center_o); // R7
endmodule

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl
  import fsel_pkg::*;
#(
  parameter int SAMPLE_CYC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] pad_fs_i,
  input  logic               pad_vsel_i,
  output logic [PAD_W-1:0]   pad_oe_o,
  input  logic               cfg_we_i,
  input  logic               cfg_addr_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  output logic               strap_done_o,
  output logic [FS_W-1:0]    fsel_o,
  output logic               fsel_chg_o,
  output logic               sprd_en_o,
  output logic               sprd_center_o,
  output logic               clk48_sel_o,
  output logic               vlow_o,
  output logic               tri_o
);
  logic [PAD_W-1:0] strap_w;
  logic             done_w;
  logic [REG_W-1:0] ctl_w;
  ctl_t             ctl_f;

  fsel_strap_sampler #(.N_CYC(SAMPLE_CYC), .W(PAD_W)) u_samp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pad_i   ({pad_vsel_i, pad_fs_i}),
    .strap_o (strap_w),
    .done_o  (done_w)
  );

  fsel_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .ctl_o   (ctl_w),
    .sel48_o (clk48_sel_o)
  );

  assign ctl_f = ctl_decode(ctl_w);

  fsel_select_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done_w),
    .src_reg_i (ctl_f.src_reg),
    .reg_fs_i  (ctl_f.fs),
    .strap_i   (strap_w[STRAP_W-1:0]),
    .fsel_o    (fsel_o),
    .chg_o     (fsel_chg_o),
    .center_o  (sprd_center_o)
  );

  assign strap_done_o = done_w;
  assign vlow_o       = strap_w[PAD_W-1];
  assign sprd_en_o    = ctl_f.sprd;
  assign tri_o        = ctl_f.tri_all;
  assign pad_oe_o     = {PAD_W{done_w & ~ctl_f.tri_all}};

  AST_OE_BEFORE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_done_o |-> pad_oe_o == '0); // R3
  AST_OE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_o |-> pad_oe_o == '0); // R3
  AST_VLOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(strap_done_o) |-> $stable(vlow_o)); // R4
endmodule

// File: tb/sim_fsel_strap_ctrl.sv
module sim_fsel_strap_ctrl;
  localparam int SAMP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pad_fs = '0;
  logic       pad_vsel = 1'b0;
  logic [4:0] pad_oe;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic       done;
  logic [4:0] fsel;
  logic       chg, sprd_en, center, c48, vlow, tri_s;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fsel_strap_ctrl #(.SAMPLE_CYC(SAMP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pad_fs_i(pad_fs), .pad_vsel_i(pad_vsel),
    .pad_oe_o(pad_oe), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .strap_done_o(done), .fsel_o(fsel), .fsel_chg_o(chg), .sprd_en_o(sprd_en),
    .sprd_center_o(center), .clk48_sel_o(c48), .vlow_o(vlow), .tri_o(tri_s)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] m_fsel(input logic [7:0] c, input logic [3:0] st);
    if (c[3]) return {c[7], c[2], c[6], c[5], c[4]};
    return {1'b0, st};
  endfunction

  function automatic logic m_center(input logic [4:0] f);
    if (f[4]) return 1'b1;
    case (f[3:0])
      4'd0, 4'd1, 4'd3, 4'd5, 4'd7, 4'd9, 4'd15: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  logic [7:0] ctl_m;
  logic [3:0] st_m;
  logic       vl_m;
  logic [4:0] prev_f;

  task automatic do_write(input logic a, input logic [7:0] d);
    logic [4:0] ef;
    prev_f = fsel;
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
    if (!a) ctl_m = d;
    // R10 direct outputs follow immediately after the write edge
    if (a) chk("R10 clk48", c48, d[7]);
    else begin
      chk("R10 sprd_en", sprd_en, d[1]);
      chk("R10 tri", tri_s, d[0]);
      chk("R3 oe", pad_oe, d[0] ? 5'h00 : 5'h1F);
    end
    chk("R9 no early update", fsel, prev_f);
    step();
    ef = m_fsel(ctl_m, st_m);
    chk("R5 fsel", fsel, ef);
    if (!ctl_m[3]) chk("R6 fs4 zero", fsel[4], 1'b0);
    chk("R8 strobe", chg, ef != prev_f);
    chk("R7 center", center, m_center(ef));
    step();
    chk("R8 strobe single", chg, 1'b0);
  endtask

  initial begin
    logic [4:0] samp [SAMP];
    logic [4:0] expst;
    void'($urandom(32'd4242));
    for (int t = 0; t < 12; t++) begin
      rst_n = 1'b0; we = 1'b0;
      pad_fs = 4'($urandom); pad_vsel = 1'($urandom);
      step();
      chk("R1 oe", pad_oe, 5'h00);
      chk("R1 done", done, 1'b0);
      chk("R1 fsel", fsel, 5'h00);
      chk("R1 chg", chg, 1'b0);
      chk("R1 sprd_en", sprd_en, 1'b1);
      chk("R1 tri", tri_s, 1'b0);
      chk("R1 clk48", c48, 1'b0);
      chk("R1 vlow", vlow, 1'b0);
      step();
      // build strap pattern: low, high, or high with one dip
      expst = '0;
      for (int p = 0; p < 5; p++) begin
        int mode;
        int dip;
        mode = (t == 0) ? 1 : (t == 1) ? 2 : int'($urandom % 3);
        dip = int'($urandom % SAMP);
        for (int s = 0; s < SAMP; s++)
          samp[s][p] = (mode == 0) ? 1'b0 : (mode == 2 && s == dip) ? 1'b0 : 1'b1;
        if (mode == 1) expst[p] = 1'b1;
      end
      ctl_m = 8'h22; st_m = expst[3:0]; vl_m = expst[4];
      rst_n = 1'b1;
      for (int s = 0; s < SAMP; s++) begin
        {pad_vsel, pad_fs} = samp[s];
        step();
        if (s == SAMP - 2) begin
          chk("R2 not yet done", done, 1'b0);
          chk("R3 oe held low", pad_oe, 5'h00);
        end
      end
      chk("R2 done", done, 1'b1);
      chk("R3 oe after latch", pad_oe, 5'h1F);
      chk("R2 vlow", vlow, vl_m);
      chk("R9 fsel not yet", fsel, 5'h00);
      {pad_vsel, pad_fs} = 5'($urandom);
      step();
      chk("R2 latched fsel", fsel, {1'b0, st_m});
      chk("R8 latch strobe", chg, st_m != 4'd0);
      chk("R7 center", center, m_center({1'b0, st_m}));
      for (int k = 0; k < 4; k++) begin
        {pad_vsel, pad_fs} = 5'($urandom);
        step();
        chk("R4 fsel hold", fsel, {1'b0, st_m});
        chk("R4 vlow hold", vlow, vl_m);
        chk("R4 no strobe", chg, 1'b0);
      end
      // directed: register source with FS4, same write again, back to straps
      do_write(1'b0, 8'hF8);
      do_write(1'b0, 8'hF8);
      do_write(1'b0, 8'h22);
      do_write(1'b1, 8'h80);
      do_write(1'b0, 8'h01);
      do_write(1'b0, 8'h0A);
      for (int w = 0; w < 14; w++) do_write(1'($urandom % 4 == 0), 8'($urandom));
      chk("R4 vlow end", vlow, vl_m);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule